// File: doc/BRIEF.md
# Byte-Lane Write-Enable Generator with Alignment Check

This block turns one host access, given as a byte address and an access size (byte, halfword or word), into four active-low byte-lane enables for a 32-bit memory bus. The lane pattern comes from the two low address bits together with the size. The same pattern is produced for reads and writes, so the enables can also drive the data-mask pins of an SDRAM.

Halfword and word accesses must be naturally aligned. A misaligned request, or one carrying the reserved size code, is not split into several bus cycles. Instead it is rejected: every lane stays high, no memory strobe is issued, and a fault flag pulses for one cycle. Requests arrive over a valid/ready handshake. The outputs are registered and appear one clock after the request is accepted. The word address (the byte address with its two low bits dropped) is passed out alongside the lanes, so consecutive word accesses four bytes apart land on adjacent word addresses.

Top module: `lane_strobe_gen`

## Requirements
- R1: A byte access (size code 2'b00) drives exactly one lane low: lane n, where n is the value of address bits 1:0. The strobe is asserted.
- R2: A lane that is not selected is held high, and in any cycle that follows no accepted request, all four lanes are high and the strobe and both fault flags are low.
- R3: A halfword access (size code 2'b01) at offset 0 gives bus_lane_n = 4'b1100, and at offset 2 it gives bus_lane_n = 4'b0011. Bit n of bus_lane_n is lane n.
- R4: A halfword access with address bit 0 set raises bus_fault_align, keeps all lanes high and issues no strobe.
- R5: A word access (size code 2'b10) at offset 0 gives bus_lane_n = 4'b0000 with the strobe asserted. At offsets 1, 2 and 3 it raises bus_fault_align with all lanes high and no strobe.
- R6: Size code 2'b11 raises bus_fault_size with all lanes high and no strobe, whatever the offset. bus_fault_align stays low.
- R7: A read (req_write = 0) produces the same lane pattern as a write of the same size and offset, and bus_write copies req_write.
- R8: All outputs change in the clock cycle after the request is accepted (req_valid and req_ready both high at a rising edge). Each accepted request gives exactly one cycle of either strobe or fault, never both.
- R9: During reset, and in the first cycle after reset is released, req_ready is low, all lanes are high and the strobe and fault flags are low. A request presented during reset is ignored. From the second cycle after release, req_ready is high.
- R10: bus_word_addr equals address bits 31:2 of the accepted request, so word accesses at byte addresses 4 apart give word addresses 1 apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Byte address of the access |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_write | input | 1 | 1 for write, 0 for read |
| bus_lane_n | output | 4 | Active-low byte-lane enables / data masks |
| bus_strobe | output | 1 | One-cycle memory strobe for a legal access |
| bus_fault_align | output | 1 | One-cycle misalignment fault |
| bus_fault_size | output | 1 | One-cycle reserved-size fault |
| bus_write | output | 1 | Registered copy of req_write |
| bus_word_addr | output | 30 | Registered word address |

## Verification
The assertions assume that the request inputs have known values at every rising edge where req_valid is high. They do not assume that a request stays steady for more than one edge. The bench changes inputs only on falling edges and returns req_valid to low between requests, so every property sees exactly one acceptance to check in the next cycle. The bench covers every size code at every offset. It also includes a request presented during reset and idle gaps, so both the active and the idle branches of each property are exercised.

// File: rtl/lane_pkg.sv
// Package: shared access-size encoding for the lane enable generator.
// Assumes a 2-bit size field; code 2'b11 is reserved and rejected.
package lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lane_decode.sv
// Module: lane_decode
// Purely combinational. Maps a byte offset and an access size to an
// active-high lane select vector and reports alignment and size faults.
// Assumes the access span (1 << size) must divide the offset exactly; any
// faulting access selects no lane.
module lane_decode
    import lane_pkg::*;
#(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size,
    output logic [LANES-1:0] lane_sel,
    output logic             align_err,
    output logic             size_err
);
    int unsigned      span;
    int unsigned      base;
    logic [LANES-1:0] in_span;

    // Span in bytes and start lane of the access.
    always_comb begin
        span = 32'd1 << size;
        base = 32'(offset);
    end

    // One comparator pair per lane: is this lane inside [base, base+span)?
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign in_span[i] = (32'(i) >= base) && (32'(i) < base + span);
    end

    // Fault classification and suppression of all lanes on a fault.
    always_comb begin
        size_err  = (size == SZ_BAD) || (span > 32'(LANES));
        align_err = !size_err && ((base & (span - 32'd1)) != 32'd0);
        lane_sel  = (size_err || align_err) ? '0 : in_span;
    end
endmodule

// File: rtl/strobe_stage.sv
// Module: strobe_stage
// Output register stage. Captures the decoded result of an accepted
// request for exactly one cycle. Lanes fall back to all-high and
// the pulses drop when nothing is accepted. Assumes 'take' is the handshake.
module strobe_stage #(
    parameter int LANES = 4,
    parameter int WA_W  = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [LANES-1:0] lane_sel,
    input  logic             align_err,
    input  logic             size_err,
    input  logic             write_in,
    input  logic [WA_W-1:0]  word_addr_in,
    output logic [LANES-1:0] lane_n,
    output logic             strobe,
    output logic             fault_align,
    output logic             fault_size,
    output logic             write_q,
    output logic [WA_W-1:0]  word_addr_q
);
    // Register the lane pattern and one-cycle strobe/fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_n      <= '1;
            strobe      <= 1'b0;
            fault_align <= 1'b0;
            fault_size  <= 1'b0;
            write_q     <= 1'b0;
            word_addr_q <= '0;
        end else begin
            lane_n      <= take ? ~lane_sel : '1;
            strobe      <= take && !(align_err || size_err);
            fault_align <= take && align_err;
            fault_size  <= take && size_err;
            if (take) begin
                write_q     <= write_in;
                word_addr_q <= word_addr_in;
            end
        end
    end
endmodule

// File: rtl/lane_strobe_gen.sv
// Module: lane_strobe_gen (top)
// Converts a byte address plus access size into registered active-low
// byte-lane enables, with alignment and size checking. Assumes DATA_W is
// a power-of-two multiple of 8; outputs follow acceptance by one cycle.
module lane_strobe_gen #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    output logic                                   req_ready,
    input  logic [ADDR_W-1:0]                      req_addr,
    input  logic [1:0]                             req_size,
    input  logic                                   req_write,
    output logic [DATA_W/8-1:0]                    bus_lane_n,
    output logic                                   bus_strobe,
    output logic                                   bus_fault_align,
    output logic                                   bus_fault_size,
    output logic                                   bus_write,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     bus_word_addr
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int WA_W  = ADDR_W - OFF_W;

    logic             take;
    logic [LANES-1:0] sel;
    logic             a_err;
    logic             s_err;

    // Ready rises one cycle after reset is released and then stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) req_ready <= 1'b0;
        else        req_ready <= 1'b1;
    end

    // Handshake completes when both sides agree.
    assign take = req_valid && req_ready;

    lane_decode #(
        .LANES (LANES),
        .OFF_W (OFF_W)
    ) u_decode (
        .offset    (req_addr[OFF_W-1:0]),
        .size      (req_size),
        .lane_sel  (sel),
        .align_err (a_err),
        .size_err  (s_err)
    );

    strobe_stage #(
        .LANES (LANES),
        .WA_W  (WA_W)
    ) u_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .lane_sel     (sel),
        .align_err    (a_err),
        .size_err     (s_err),
        .write_in     (req_write),
        .word_addr_in (req_addr[ADDR_W-1:OFF_W]),
        .lane_n       (bus_lane_n),
        .strobe       (bus_strobe),
        .fault_align  (bus_fault_align),
        .fault_size   (bus_fault_size),
        .write_q      (bus_write),
        .word_addr_q  (bus_word_addr)
    );
endmodule

// File: rtl/lane_strobe_gen_chk.sv
// Module: lane_strobe_gen_chk
// Protocol checker bound to lane_strobe_gen. Relates each accepted request
// to the registered outputs one cycle later. Assumes request inputs are
// known whenever req_valid is high at a rising edge.
module lane_strobe_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [LANES-1:0]  bus_lane_n,
    input logic              bus_strobe,
    input logic              bus_fault_align,
    input logic              bus_fault_size
);
    logic acc;
    assign acc = req_valid && req_ready;

    assert_byte_one_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_size == 2'b00 |=> bus_strobe && $countones(~bus_lane_n) == 1);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> bus_lane_n == '1 && !bus_strobe && !bus_fault_align && !bus_fault_size);

    assert_half_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_size == 2'b01 && !req_addr[0] |=> bus_strobe && $countones(~bus_lane_n) == 2);

    assert_half_misalign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_size == 2'b01 && req_addr[0] |=> bus_fault_align && !bus_strobe && bus_lane_n == '1);

    assert_word_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_size == 2'b10 && req_addr[1:0] == 2'b00 |=> bus_strobe && bus_lane_n == '0);

    assert_bad_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_size == 2'b11 |=> bus_fault_size && !bus_fault_align && !bus_strobe && bus_lane_n == '1);

    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> $countones({bus_strobe, bus_fault_align, bus_fault_size}) == 1);

    assert_fault_lanes_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fault_align || bus_fault_size) |-> bus_lane_n == '1);
endmodule

bind lane_strobe_gen lane_strobe_gen_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_addr        (req_addr),
    .req_size        (req_size),
    .bus_lane_n      (bus_lane_n),
    .bus_strobe      (bus_strobe),
    .bus_fault_align (bus_fault_align),
    .bus_fault_size  (bus_fault_size)
);

// File: tb/lane_strobe_gen_test.sv
// Directed bench for lane_strobe_gen: one task per scenario, each checking
// its own results at the falling edge after the capturing rising edge.
module lane_strobe_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [3:0]  bus_lane_n;
    logic        bus_strobe;
    logic        bus_fault_align;
    logic        bus_fault_size;
    logic        bus_write;
    logic [29:0] bus_word_addr;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_strobe_gen uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_addr        (req_addr),
        .req_size        (req_size),
        .req_write       (req_write),
        .bus_lane_n      (bus_lane_n),
        .bus_strobe      (bus_strobe),
        .bus_fault_align (bus_fault_align),
        .bus_fault_size  (bus_fault_size),
        .bus_write       (bus_write),
        .bus_word_addr   (bus_word_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Presents one request for one rising edge, then samples the result.
    task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Packs the observed outcome: {lanes, strobe, align fault, size fault}.
    function automatic logic [31:0] outcome();
        return {25'd0, bus_lane_n, bus_strobe, bus_fault_align, bus_fault_size};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        req_valid = 1'b1; req_size = 2'b10; req_addr = 32'h0;
        repeat (3) @(negedge clk);
        chk(outcome() == {25'd0, 4'hF, 3'b000}, "R9 reset outputs", outcome(), {25'd0, 4'hF, 3'b000});
        chk(req_ready == 1'b0, "R9 ready low in reset", 32'(req_ready), 32'd0);
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(outcome() == {25'd0, 4'hF, 3'b000}, "R9 request in reset ignored", outcome(), {25'd0, 4'hF, 3'b000});
        chk(req_ready == 1'b1, "R9 ready after release", 32'(req_ready), 32'd1);
    endtask

    task automatic t_bytes();
        for (int k = 0; k < 4; k++) begin
            issue(32'h3000_0000 + 32'(k), 2'b00, 1'b1);
            chk(bus_lane_n == ~(4'b0001 << k) && bus_strobe, "R1 byte lane",
                32'(bus_lane_n), 32'(~(4'b0001 << k)));
        end
    endtask

    task automatic t_halves();
        issue(32'h3000_0000, 2'b01, 1'b1);
        chk(bus_lane_n == 4'b1100 && bus_strobe, "R3 half offset 0", 32'(bus_lane_n), 32'hC);
        issue(32'h3000_0002, 2'b01, 1'b1);
        chk(bus_lane_n == 4'b0011 && bus_strobe, "R3 half offset 2", 32'(bus_lane_n), 32'h3);
        for (int k = 1; k < 4; k += 2) begin
            issue(32'h3000_0000 + 32'(k), 2'b01, 1'b1);
            chk(outcome() == {25'd0, 4'hF, 3'b010}, "R4 half misaligned", outcome(), {25'd0, 4'hF, 3'b010});
        end
    endtask

    task automatic t_words();
        issue(32'h3000_0000, 2'b10, 1'b1);
        chk(outcome() == {25'd0, 4'h0, 3'b100}, "R5 word aligned", outcome(), {25'd0, 4'h0, 3'b100});
        for (int k = 1; k < 4; k++) begin
            issue(32'h3000_0000 + 32'(k), 2'b10, 1'b1);
            chk(outcome() == {25'd0, 4'hF, 3'b010}, "R5 word misaligned", outcome(), {25'd0, 4'hF, 3'b010});
        end
    endtask

    task automatic t_bad_size();
        for (int k = 0; k < 4; k++) begin
            issue(32'h3000_0000 + 32'(k), 2'b11, 1'b1);
            chk(outcome() == {25'd0, 4'hF, 3'b001}, "R6 reserved size", outcome(), {25'd0, 4'hF, 3'b001});
        end
    endtask

    task automatic t_reads();
        issue(32'h3000_0002, 2'b01, 1'b0);
        chk(bus_lane_n == 4'b0011 && bus_write == 1'b0, "R7 read half mask", 32'(bus_lane_n), 32'h3);
        issue(32'h3000_0003, 2'b00, 1'b0);
        chk(bus_lane_n == 4'b0111 && bus_write == 1'b0, "R7 read byte mask", 32'(bus_lane_n), 32'h7);
        issue(32'h3000_0003, 2'b00, 1'b1);
        chk(bus_write == 1'b1, "R7 write flag", 32'(bus_write), 32'd1);
    endtask

    task automatic t_timing_idle();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h3000_0001; req_size = 2'b00;
        #1;
        chk(bus_strobe == 1'b0 && bus_lane_n == 4'hF, "R8 no change before edge", 32'(bus_lane_n), 32'hF);
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_lane_n == 4'b1101 && bus_strobe, "R8 change after edge", 32'(bus_lane_n), 32'hD);
        @(negedge clk);
        chk(outcome() == {25'd0, 4'hF, 3'b000}, "R2 idle after pulse", outcome(), {25'd0, 4'hF, 3'b000});
        issue(32'h3000_0001, 2'b10, 1'b1);
        @(negedge clk);
        chk(outcome() == {25'd0, 4'hF, 3'b000}, "R2 idle after fault", outcome(), {25'd0, 4'hF, 3'b000});
    endtask

    task automatic t_word_addr();
        issue(32'h3000_0100, 2'b10, 1'b1);
        chk(bus_word_addr == 30'h0C00_0040, "R10 word address", 32'(bus_word_addr), 32'h0C00_0040);
        issue(32'h3000_0104, 2'b10, 1'b1);
        chk(bus_word_addr == 30'h0C00_0041, "R10 next word address", 32'(bus_word_addr), 32'h0C00_0041);
        issue(32'h3000_0107, 2'b00, 1'b1);
        chk(bus_word_addr == 30'h0C00_0041 && bus_lane_n == 4'b0111, "R10 byte in word",
            32'(bus_word_addr), 32'h0C00_0041);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL R8 watchdog expired actual=%0d expected=0", 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_bytes();
        t_halves();
        t_words();
        t_bad_size();
        t_reads();
        t_timing_idle();
        t_word_addr();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule